// File: doc/BRIEF.md
# Condition Code Evaluator with Conditional Move

This block turns a 4-bit condition selector and the five status flags (zero, sign, overflow, carry, saturation) into a single true/false decision. It then uses that decision in one of two operations. A conditional move passes on either a first operand or a second register value. The first operand is either a 32-bit register value or a 5-bit immediate sign-extended to 32 bits. A set-flag operation produces the constant 1 or 0.

The same 16-entry condition table serves branches, conditional moves and set-flag writes. In that table, codes that differ only in bit 3 are complementary tests, except for one pair. In that pair, code 0x5 is unconditionally true and code 0xD tests the saturation flag. Several mnemonics share an entry: carry and unsigned-lower are one code, and so are no-carry and unsigned-not-lower.

An execution pipeline presents one request per cycle with `req_valid`. With the default parameters the result leaves through an output register one cycle later. The register file, instruction decode and flag updates are outside this block.

Top module: `ccmov_unit`

## Requirements
- R1: Code 0x0 is true when overflow is set, and code 0x8 is true when overflow is clear.
- R2: Code 0x1 (carry / unsigned lower) is true when carry is set, and code 0x9 is true when carry is clear.
- R3: Code 0x2 is true when zero is set, and code 0xA is true when zero is clear.
- R4: Code 0x3 (unsigned not-higher) is true when (carry OR zero) is 1, and code 0xB (unsigned higher) is true when (carry OR zero) is 0.
- R5: Code 0x4 is true when sign is set, and code 0xC is true when sign is clear.
- R6: Code 0x6 (signed less) is true when (sign XOR overflow) is 1, and code 0xE (signed greater-or-equal) is true when it is 0.
- R7: Code 0x7 (signed less-or-equal) is true when ((sign XOR overflow) OR zero) is 1, and code 0xF (signed greater) is true when it is 0.
- R8: Code 0x5 is true for every flag combination.
- R9: Code 0xD is true exactly when the saturation flag is set.
- R10: With `op_setf`=0 and `use_imm`=0, the result is `opnd_a` when the condition holds and `opnd_b` otherwise.
- R11: With `op_setf`=0 and `use_imm`=1, `imm_val` is sign-extended from bit 4 to 32 bits and takes the place of `opnd_a`. In this mode `opnd_a` has no effect on the result.
- R12: With `op_setf`=1, the result is 32'd1 when the condition holds and 32'd0 otherwise, whatever the operands are.
- R13: A request accepted on a rising edge is visible on `res_valid`/`res_data` after that edge. A cycle with `req_valid`=0 gives `res_valid`=0 and `res_data`=0 after the next edge. Reset clears both outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present this cycle |
| cond_sel | input | 4 | Condition selector |
| flag_z | input | 1 | Zero flag |
| flag_s | input | 1 | Sign flag |
| flag_ov | input | 1 | Overflow flag |
| flag_cy | input | 1 | Carry flag |
| flag_sat | input | 1 | Saturation flag |
| op_setf | input | 1 | 0 = conditional move, 1 = set-flag |
| use_imm | input | 1 | Conditional move takes the immediate as its first operand |
| imm_val | input | 5 | Signed 5-bit immediate |
| opnd_a | input | 32 | First register operand |
| opnd_b | input | 32 | Second register operand |
| res_valid | output | 1 | Result present |
| res_data | output | 32 | Result value |

## Verification
The clocked properties assume that the inputs of an accepted request are stable around the sampling edge. They also assume that the registered output variant is built, since they relate one cycle's request to the next cycle's result. The stimulus changes inputs only on falling edges. It walks every selector through all 32 flag combinations in each of the three operation modes, and interleaves idle cycles so that the output clearing is exercised. Operand values are drawn so that the first and second operands always differ. For each immediate case, `opnd_a` is chosen so that it disagrees with the extended immediate. This means a wrong selection always shows at the port.

// File: rtl/ccmov_pkg.sv
package ccmov_pkg;

    localparam int DATA_W = 32;
    localparam int IMM_W  = 5;

    typedef struct packed {
        logic z;
        logic s;
        logic ov;
        logic cy;
        logic sat;
    } flags_t;

    typedef enum logic [3:0] {
        CC_OVF       = 4'h0,
        CC_CARRY     = 4'h1,
        CC_ZERO      = 4'h2,
        CC_NOT_ABOVE = 4'h3,
        CC_NEG       = 4'h4,
        CC_ALWAYS    = 4'h5,
        CC_LESS      = 4'h6,
        CC_LESS_EQ   = 4'h7,
        CC_NO_OVF    = 4'h8,
        CC_NO_CARRY  = 4'h9,
        CC_NONZERO   = 4'hA,
        CC_ABOVE     = 4'hB,
        CC_POS       = 4'hC,
        CC_SATURATED = 4'hD,
        CC_GREAT_EQ  = 4'hE,
        CC_GREATER   = 4'hF
    } cond_t;

    typedef enum logic {
        OP_CMOV = 1'b0,
        OP_SETF = 1'b1
    } op_t;

    typedef struct packed {
        cond_t               cond;
        flags_t              flg;
        op_t                 op;
        logic                use_imm;
        logic [IMM_W-1:0]    imm;
        logic [DATA_W-1:0]   a;
        logic [DATA_W-1:0]   b;
    } req_t;

    // Base test for the low three selector bits; bit 3 inverts it.
    function automatic logic base_test(input logic [2:0] low, input flags_t f);
        logic r;
        case (low)
            3'd0:    r = f.ov;
            3'd1:    r = f.cy;
            3'd2:    r = f.z;
            3'd3:    r = f.cy | f.z;
            3'd4:    r = f.s;
            3'd6:    r = f.s ^ f.ov;
            3'd7:    r = (f.s ^ f.ov) | f.z;
            default: r = 1'b1;
        endcase
        return r;
    endfunction

    function automatic logic [DATA_W-1:0] sext_imm(input logic [IMM_W-1:0] v);
        return {{(DATA_W-IMM_W){v[IMM_W-1]}}, v};
    endfunction

endpackage

// File: rtl/ccmov_cond_eval.sv
module ccmov_cond_eval
    import ccmov_pkg::*;
(
    input  cond_t  cond,
    input  flags_t flg,
    output logic   holds
);
    logic [2:0] low;
    logic       inv;
    logic       base;

    assign low  = cond[2:0];
    assign inv  = cond[3];
    assign base = base_test(low, flg);

    // Entry 5 breaks the complement pattern: plain 5 is always, 5|8 is saturation.
    always_comb begin
        if (low == 3'd5) holds = inv ? flg.sat : 1'b1;
        else             holds = base ^ inv;
    end
endmodule

// File: rtl/ccmov_datapath.sv
module ccmov_datapath
    import ccmov_pkg::*;
(
    input  req_t              req,
    input  logic              holds,
    output logic [DATA_W-1:0] value
);
    logic [DATA_W-1:0] first;
    logic [DATA_W-1:0] moved;
    logic [DATA_W-1:0] flagval;

    assign first   = req.use_imm ? sext_imm(req.imm) : req.a;
    assign moved   = holds ? first : req.b;
    assign flagval = {{(DATA_W-1){1'b0}}, holds};

    always_comb begin
        case (req.op)
            OP_SETF: value = flagval;
            default: value = moved;
        endcase
    end
endmodule

// File: rtl/ccmov_out_stage.sv
module ccmov_out_stage
    import ccmov_pkg::*;
#(
    parameter bit REGISTER_OUT = 1'b1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] in_data,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_data
);
    generate
        if (REGISTER_OUT) begin : g_reg
            logic              v_q;
            logic [DATA_W-1:0] d_q;
            always_ff @(posedge clk) begin
                if (rst) begin
                    v_q <= 1'b0;
                    d_q <= '0;
                end else begin
                    v_q <= in_valid;
                    d_q <= in_valid ? in_data : '0;
                end
            end
            assign out_valid = v_q;
            assign out_data  = d_q;

            p_idle_zero_r13: assert property (@(posedge clk) disable iff (rst)
                !in_valid |=> (!out_valid && out_data == '0));
            p_accept_r13: assert property (@(posedge clk) disable iff (rst)
                in_valid |=> out_valid);
        end else begin : g_comb
            assign out_valid = in_valid;
            assign out_data  = in_valid ? in_data : '0;
        end
    endgenerate
endmodule

// File: rtl/ccmov_unit.sv
module ccmov_unit
    import ccmov_pkg::*;
#(
    parameter bit REGISTER_OUT = 1'b1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic [3:0]        cond_sel,
    input  logic              flag_z,
    input  logic              flag_s,
    input  logic              flag_ov,
    input  logic              flag_cy,
    input  logic              flag_sat,
    input  logic              op_setf,
    input  logic              use_imm,
    input  logic [IMM_W-1:0]  imm_val,
    input  logic [DATA_W-1:0] opnd_a,
    input  logic [DATA_W-1:0] opnd_b,
    output logic              res_valid,
    output logic [DATA_W-1:0] res_data
);
    req_t              req;
    logic              holds;
    logic [DATA_W-1:0] value;

    always_comb begin
        req.cond    = cond_t'(cond_sel);
        req.flg     = '{z: flag_z, s: flag_s, ov: flag_ov, cy: flag_cy, sat: flag_sat};
        req.op      = op_setf ? OP_SETF : OP_CMOV;
        req.use_imm = use_imm;
        req.imm     = imm_val;
        req.a       = opnd_a;
        req.b       = opnd_b;
    end

    ccmov_cond_eval u_eval (
        .cond  (req.cond),
        .flg   (req.flg),
        .holds (holds)
    );

    ccmov_datapath u_dp (
        .req   (req),
        .holds (holds),
        .value (value)
    );

    ccmov_out_stage #(.REGISTER_OUT(REGISTER_OUT)) u_out (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (req_valid),
        .in_data   (value),
        .out_valid (res_valid),
        .out_data  (res_data)
    );

    generate
        if (REGISTER_OUT) begin : g_chk
            p_always_true_r8: assert property (@(posedge clk) disable iff (rst)
                (req_valid && op_setf && cond_sel == 4'h5) |=> (res_data == 32'd1));
            p_sat_test_r9: assert property (@(posedge clk) disable iff (rst)
                (req_valid && op_setf && cond_sel == 4'hD) |=> (res_data[0] == $past(flag_sat)));
            p_zero_test_r3: assert property (@(posedge clk) disable iff (rst)
                (req_valid && op_setf && cond_sel == 4'h2) |=> (res_data[0] == $past(flag_z)));
            p_setf_bool_r12: assert property (@(posedge clk) disable iff (rst)
                (req_valid && op_setf) |=> (res_data[DATA_W-1:1] == '0));
            p_cmov_pick_r10: assert property (@(posedge clk) disable iff (rst)
                (req_valid && !op_setf && !use_imm) |=>
                    (res_data == $past(opnd_a) || res_data == $past(opnd_b)));
        end
    endgenerate
endmodule

// File: tb/ccmov_unit_bench.sv
`timescale 1ns/1ps
module ccmov_unit_bench;
    logic        clk = 1'b0;
    logic        rst;
    logic        req_valid;
    logic [3:0]  cond_sel;
    logic        flag_z, flag_s, flag_ov, flag_cy, flag_sat;
    logic        op_setf, use_imm;
    logic [4:0]  imm_val;
    logic [31:0] opnd_a, opnd_b;
    logic        res_valid;
    logic [31:0] res_data;

    int checks = 0;
    int errors = 0;

    bit          exp_v;
    logic [31:0] exp_d;
    string       exp_tag;

    always #2.5 clk = ~clk;

    ccmov_unit u_ccmov_unit (
        .clk(clk), .rst(rst), .req_valid(req_valid), .cond_sel(cond_sel),
        .flag_z(flag_z), .flag_s(flag_s), .flag_ov(flag_ov), .flag_cy(flag_cy),
        .flag_sat(flag_sat), .op_setf(op_setf), .use_imm(use_imm), .imm_val(imm_val),
        .opnd_a(opnd_a), .opnd_b(opnd_b), .res_valid(res_valid), .res_data(res_data)
    );

    function automatic bit ref_cond(int code, bit z, bit s, bit ov, bit cy, bit sat);
        case (code)
            0:  return ov;
            8:  return !ov;
            1:  return cy;
            9:  return !cy;
            2:  return z;
            10: return !z;
            3:  return cy || z;
            11: return !(cy || z);
            4:  return s;
            12: return !s;
            5:  return 1'b1;
            13: return sat;
            6:  return s != ov;
            14: return s == ov;
            7:  return (s != ov) || z;
            default: return !((s != ov) || z);
        endcase
    endfunction

    function automatic string code_tag(int code);
        case (code % 8)
            0: return "R1";
            1: return "R2";
            2: return "R3";
            3: return "R4";
            4: return "R5";
            6: return "R6";
            7: return "R7";
            default: return (code == 5) ? "R8" : "R9";
        endcase
    endfunction

    task automatic check_out();
        checks++;
        if (res_valid !== exp_v || res_data !== exp_d) begin
            errors++;
            $display("FAIL %s: valid=%0b data=%h expected valid=%0b data=%h",
                     exp_tag, res_valid, res_data, exp_v, exp_d);
        end
    endtask

    initial begin
        #(5.0 * 200000);
        errors++;
        $display("FAIL watchdog: run did not finish, actual=hung expected=done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int step = 0;
        rst = 1'b1; req_valid = 1'b0; cond_sel = '0;
        {flag_z, flag_s, flag_ov, flag_cy, flag_sat} = '0;
        op_setf = 1'b0; use_imm = 1'b0; imm_val = '0; opnd_a = '0; opnd_b = '0;
        repeat (3) @(negedge clk);
        // R13: reset state
        exp_v = 1'b0; exp_d = '0; exp_tag = "R13 reset";
        check_out();
        rst = 1'b0;
        exp_tag = "R13 idle";
        for (int mode = 0; mode < 3; mode++) begin
            for (int code = 0; code < 16; code++) begin
                for (int f = 0; f < 32; f++) begin
                    bit c;
                    bit z, s, ov, cy, sat;
                    logic [31:0] ext;
                    @(negedge clk);
                    check_out();
                    step++;
                    if (step % 7 == 0) begin
                        // R13: idle cycle clears output
                        req_valid = 1'b0;
                        opnd_a = $urandom;
                        exp_v = 1'b0; exp_d = '0; exp_tag = "R13 idle";
                        @(negedge clk);
                        check_out();
                    end
                    {z, s, ov, cy, sat} = f[4:0];
                    {flag_z, flag_s, flag_ov, flag_cy, flag_sat} = f[4:0];
                    cond_sel  = code[3:0];
                    req_valid = 1'b1;
                    opnd_b    = $urandom;
                    opnd_a    = opnd_b ^ (32'h1 << (f % 32));
                    imm_val   = 5'(f + code);
                    ext       = {{27{imm_val[4]}}, imm_val};
                    op_setf   = (mode == 2);
                    use_imm   = (mode == 1);
                    if (mode == 1) begin
                        // R11: opnd_a must not leak into the result
                        opnd_a = ~ext;
                        if (opnd_b == ext) opnd_b = ext ^ 32'h8000_0000;
                    end
                    c = ref_cond(code, z, s, ov, cy, sat);
                    exp_v = 1'b1;
                    case (mode)
                        0: begin exp_d = c ? opnd_a : opnd_b; exp_tag = {code_tag(code), "/R10"}; end
                        1: begin exp_d = c ? ext : opnd_b;    exp_tag = {code_tag(code), "/R11"}; end
                        default: begin exp_d = c ? 32'd1 : 32'd0; exp_tag = {code_tag(code), "/R12"}; end
                    endcase
                    if (mode == 2) begin
                        opnd_a = $urandom; opnd_b = $urandom; use_imm = f[0];
                    end
                end
            end
        end
        @(negedge clk);
        check_out();
        req_valid = 1'b0;
        exp_v = 1'b0; exp_d = '0; exp_tag = "R13 drain";
        @(negedge clk);
        check_out();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule